// File: doc/BRIEF.md
# Decode Stage with Early Branch Resolution

This block is the decode stage of a simple in-order 32-bit RISC core. Each cycle it receives the fetched instruction, that instruction's PC, a fetch-valid flag and the instruction cache's hit flag, which arrives in the same cycle. It turns the instruction into execute-stage control signals. It always drives the two register-file read addresses from fixed instruction fields, and it forwards results from the two instructions ahead of it. The decoded instruction and its operands are registered into the execute stage.

Branches are resolved inside this stage, so the core needs only one delay slot. The target adder runs for every instruction, and its result is used only when the instruction is a taken branch. When the fetch missed in the cache, the instruction becomes a bubble. When the instruction one stage ahead is a load the current instruction depends on, the stage raises `stall`. It does the same when a branch needs a value that the instruction one stage ahead is still computing. While stalled, the stage holds its instruction and sends a bubble to execute.

Top module: `early_branch_decode`

## Requirements
- R1: During and right after reset, `x_valid` is 0.
- R2: Instruction layout: opcode is bits 31:26, source A is 25:21, source B is 20:16, register destination is 15:11, and the immediate is bits 15:0, sign-extended to 32 bits. Opcodes: 0 register op, 1 add-immediate, 2 load, 3 store, 4 branch-if-equal, 5 branch-if-not-equal. For opcode 0, bits 10:2 must be 0 and bits 1:0 select `x_alu_op` (0 add, 1 subtract, 2 and, 3 or); every other opcode issues `x_alu_op` 0. Add-immediate and load write the register in bits 20:16 and set `x_use_imm`. A store writes nothing, sets `x_use_imm`, and its store data is `x_opnd_b`. A destination of register 0 leaves `x_wr_en` at 0. The registered outputs appear one clock edge after decode.
- R3: `rf_addr_a` always equals bits 25:21 and `rf_addr_b` always equals bits 20:16, whatever the opcode.
- R4: Each operand comes from the one-stage-ahead result when that instruction writes the same register. Failing that, it comes from the two-stage-ahead result, and failing that, from the register file. Register 0 never forwards.
- R5: If the one-stage-ahead instruction is a load that writes a source the current instruction reads, `stall` is 1 in that cycle and the next `x_valid` is 0.
- R6: Bits 20:16 are not a source for add-immediate or load, so a match on that field never causes a stall.
- R7: `redirect_target` is the PC plus the sign-extended immediate shifted left by two. `redirect_valid` is 1 in the decode cycle of a taken branch and only then.
- R8: Branch-if-equal is taken when the two forwarded operands are equal; branch-if-not-equal is taken when they differ.
- R9: A branch that reads a register being written by the one-stage-ahead instruction stalls for that cycle and raises no redirect.
- R10: When `id_hit` is 0, the instruction gives a bubble, with no stall and no redirect.
- R11: An undefined opcode, or a register op with nonzero bits 10:2, gives a bubble, with no stall and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | A fetched instruction is present |
| id_instr | input | 32 | Fetched instruction |
| id_pc | input | 32 | PC of the fetched instruction |
| id_hit | input | 1 | Cache tag check hit for this fetch |
| rf_addr_a | output | 5 | Register file read address A |
| rf_addr_b | output | 5 | Register file read address B |
| rf_data_a | input | 32 | Register file read data A |
| rf_data_b | input | 32 | Register file read data B |
| ex_wr_en | input | 1 | One-stage-ahead instruction writes a register |
| ex_load | input | 1 | One-stage-ahead instruction is a load |
| ex_rd | input | 5 | One-stage-ahead destination register |
| ex_result | input | 32 | One-stage-ahead result |
| mem_wr_en | input | 1 | Two-stage-ahead instruction writes a register |
| mem_rd | input | 5 | Two-stage-ahead destination register |
| mem_result | input | 32 | Two-stage-ahead result, including load data |
| stall | output | 1 | Hold fetch and decode this cycle |
| redirect_valid | output | 1 | Taken branch; fetch loads the target after the delay slot |
| redirect_target | output | 32 | Branch target address |
| x_valid | output | 1 | Registered: instruction valid in execute |
| x_alu_op | output | 2 | Registered: ALU operation |
| x_wr_en | output | 1 | Registered: writes a register |
| x_load | output | 1 | Registered: is a load |
| x_store | output | 1 | Registered: is a store |
| x_use_imm | output | 1 | Registered: second ALU operand is the immediate |
| x_rd | output | 5 | Registered: destination register |
| x_opnd_a | output | 32 | Registered: forwarded operand A |
| x_opnd_b | output | 32 | Registered: forwarded operand B |
| x_imm | output | 32 | Registered: sign-extended immediate |

## Verification
Operand selection is tried with no producer ahead, a producer only one stage ahead, a producer only two stages ahead, producers at both stages for the same register, and a producer writing register 0; together these separate the priority order from the register-0 exception. Load-use patterns put the match on source A, on source B of a register op, and on bits 20:16 of an add-immediate, which tells a real dependency from the unused extra read. Branches run taken and not taken for both conditions, with a negative offset, and with an operand one stage ahead that forces a stall and then resolves through the two-stage path. Cache misses and illegal encodings are applied on top of a hazard and a branch, to show they suppress stall and redirect as well as the issue.

// File: rtl/early_branch_decode.sv
module early_branch_decode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        id_valid,
  input  logic [31:0] id_instr,
  input  logic [31:0] id_pc,
  input  logic        id_hit,
  output logic [4:0]  rf_addr_a,
  output logic [4:0]  rf_addr_b,
  input  logic [31:0] rf_data_a,
  input  logic [31:0] rf_data_b,
  input  logic        ex_wr_en,
  input  logic        ex_load,
  input  logic [4:0]  ex_rd,
  input  logic [31:0] ex_result,
  input  logic        mem_wr_en,
  input  logic [4:0]  mem_rd,
  input  logic [31:0] mem_result,
  output logic        stall,
  output logic        redirect_valid,
  output logic [31:0] redirect_target,
  output logic        x_valid,
  output logic [1:0]  x_alu_op,
  output logic        x_wr_en,
  output logic        x_load,
  output logic        x_store,
  output logic        x_use_imm,
  output logic [4:0]  x_rd,
  output logic [31:0] x_opnd_a,
  output logic [31:0] x_opnd_b,
  output logic [31:0] x_imm
);
  localparam logic [5:0] OP_REG   = 6'd0;
  localparam logic [5:0] OP_ADDI  = 6'd1;
  localparam logic [5:0] OP_LOAD  = 6'd2;
  localparam logic [5:0] OP_STORE = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;

  logic [5:0]  opcode;
  logic [4:0]  src_a, src_b, dst_r, dest;
  logic [31:0] imm, opnd_a, opnd_b;
  logic is_reg, is_addi, is_load, is_store, is_beq, is_bne, is_branch;
  logic live, reads_b, writes, ex_dep_a, ex_dep_b, issue, taken;

  assign opcode = id_instr[31:26];
  assign src_a  = id_instr[25:21];
  assign src_b  = id_instr[20:16];
  assign dst_r  = id_instr[15:11];
  assign imm    = {{16{id_instr[15]}}, id_instr[15:0]};

  assign is_reg    = (opcode == OP_REG) && (id_instr[10:2] == 9'd0);
  assign is_addi   = opcode == OP_ADDI;
  assign is_load   = opcode == OP_LOAD;
  assign is_store  = opcode == OP_STORE;
  assign is_beq    = opcode == OP_BEQ;
  assign is_bne    = opcode == OP_BNE;
  assign is_branch = is_beq | is_bne;

  assign live    = id_valid & id_hit & (is_reg | is_addi | is_load | is_store | is_branch);
  assign reads_b = is_reg | is_store | is_branch;
  assign dest    = is_reg ? dst_r : src_b;
  assign writes  = (is_reg | is_addi | is_load) && (dest != 5'd0);

  assign rf_addr_a = src_a;
  assign rf_addr_b = src_b;

  assign opnd_a = (src_a != 5'd0 && ex_wr_en && ex_rd == src_a)   ? ex_result  :
                  (src_a != 5'd0 && mem_wr_en && mem_rd == src_a) ? mem_result : rf_data_a;
  assign opnd_b = (src_b != 5'd0 && ex_wr_en && ex_rd == src_b)   ? ex_result  :
                  (src_b != 5'd0 && mem_wr_en && mem_rd == src_b) ? mem_result : rf_data_b;

  assign ex_dep_a = ex_wr_en && (ex_rd != 5'd0) && (ex_rd == src_a);
  assign ex_dep_b = ex_wr_en && (ex_rd != 5'd0) && (ex_rd == src_b) && reads_b;

  assign stall = live && (ex_dep_a || ex_dep_b) && (ex_load || is_branch);
  assign issue = live && !stall;

  assign taken           = is_beq ? (opnd_a == opnd_b) : (opnd_a != opnd_b);
  assign redirect_valid  = issue && is_branch && taken;
  assign redirect_target = id_pc + {imm[29:0], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_valid   <= 1'b0;
      x_alu_op  <= 2'd0;
      x_wr_en   <= 1'b0;
      x_load    <= 1'b0;
      x_store   <= 1'b0;
      x_use_imm <= 1'b0;
      x_rd      <= 5'd0;
      x_opnd_a  <= 32'd0;
      x_opnd_b  <= 32'd0;
      x_imm     <= 32'd0;
    end else begin
      x_valid   <= issue;
      x_alu_op  <= is_reg ? id_instr[1:0] : 2'd0;
      x_wr_en   <= issue && writes;
      x_load    <= issue && is_load;
      x_store   <= issue && is_store;
      x_use_imm <= is_addi | is_load | is_store;
      x_rd      <= writes ? dest : 5'd0;
      x_opnd_a  <= opnd_a;
      x_opnd_b  <= opnd_b;
      x_imm     <= imm;
    end
  end
endmodule

module early_branch_decode_chk (
  input logic clk,
  input logic rst_n,
  input logic id_valid,
  input logic id_hit,
  input logic stall,
  input logic redirect_valid,
  input logic x_valid,
  input logic x_wr_en
);
  // R5
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !x_valid);
  // R10
  miss_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_hit |=> !x_valid);
  // R10
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_hit |-> (!stall && !redirect_valid));
  // R9
  redirect_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (!stall && id_valid));
  // R2
  write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_wr_en |-> x_valid);
endmodule

bind early_branch_decode early_branch_decode_chk chk_i (.*);

// File: tb/early_branch_decode_tb_top.sv
`timescale 1ns/1ps
module early_branch_decode_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        id_valid = 0, id_hit = 0;
  logic [31:0] id_instr = 0, id_pc = 0, rf_data_a = 0, rf_data_b = 0;
  logic        ex_wr_en = 0, ex_load = 0, mem_wr_en = 0;
  logic [4:0]  ex_rd = 0, mem_rd = 0;
  logic [31:0] ex_result = 0, mem_result = 0;
  logic [4:0]  rf_addr_a, rf_addr_b, x_rd;
  logic        stall, redirect_valid, x_valid, x_wr_en, x_load, x_store, x_use_imm;
  logic [31:0] redirect_target, x_opnd_a, x_opnd_b, x_imm;
  logic [1:0]  x_alu_op;

  early_branch_decode dut_i (.*);

  typedef struct packed {
    logic v; logic [1:0] op; logic we, ld, st, ui; logic [4:0] rd;
    logic [31:0] a, b, imm;
  } exp_t;

  exp_t  q[$];
  string rq[$];
  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input logic ok, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 9'd0, fn[1:0]};
  endfunction
  function automatic logic [31:0] itype(input int op, input int rs, input int rt, input logic [15:0] im);
    return {op[5:0], rs[4:0], rt[4:0], im};
  endfunction

  function automatic logic [31:0] pickv(input logic [4:0] r, input logic [31:0] rf);
    if (r == 0) return rf;
    if (ex_wr_en && ex_rd == r) return ex_result;
    if (mem_wr_en && mem_rd == r) return mem_result;
    return rf;
  endfunction

  // Reference expectations from the requirement text
  task automatic go(input string req);
    logic [5:0] op; logic [4:0] rs, rt, dr; logic legal, live, brn, usesb, hz, st, eq, rdr;
    logic [31:0] a, b, tgt; exp_t e;
    #1;
    op = id_instr[31:26]; rs = id_instr[25:21]; rt = id_instr[20:16];
    case (op)
      6'd0: legal = (id_instr[10:2] == 0);
      6'd1, 6'd2, 6'd3, 6'd4, 6'd5: legal = 1;
      default: legal = 0;
    endcase
    live  = id_valid && id_hit && legal;
    brn   = (op == 4) || (op == 5);
    usesb = (op == 0) || (op == 3) || brn;
    hz    = ex_wr_en && ex_rd != 0 && (ex_rd == rs || (usesb && ex_rd == rt));
    st    = live && hz && (ex_load || brn);
    a = pickv(rs, rf_data_a); b = pickv(rt, rf_data_b);
    eq  = (a == b);
    rdr = live && !st && brn && ((op == 4) ? eq : !eq);
    tgt = id_pc + {{14{id_instr[15]}}, id_instr[15:0], 2'b00};
    dr  = (op == 0) ? id_instr[15:11] : rt;
    e.v   = live && !st;
    e.op  = (op == 0) ? id_instr[1:0] : 2'd0;
    e.we  = e.v && (op <= 2) && dr != 0;
    e.ld  = e.v && op == 2;
    e.st  = e.v && op == 3;
    e.ui  = (op >= 1 && op <= 3);
    e.rd  = ((op <= 2) && dr != 0) ? dr : 5'd0;
    e.a = a; e.b = b; e.imm = {{16{id_instr[15]}}, id_instr[15:0]};
    check({req, " R3 read addr"}, rf_addr_a == rs && rf_addr_b == rt,
          {rf_addr_a, rf_addr_b}, {rs, rt});
    check({req, " stall"}, stall == st, stall, st);
    check({req, " redirect"}, redirect_valid == rdr, redirect_valid, rdr);
    if (rdr) check({req, " R7 target"}, redirect_target == tgt, redirect_target, tgt);
    q.push_back(e); rq.push_back(req);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    exp_t e; string r; logic [108:0] act;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front(); r = rq.pop_front();
      act = {x_valid, x_alu_op, x_wr_en, x_load, x_store, x_use_imm, x_rd, x_opnd_a, x_opnd_b, x_imm};
      if (e.v) check({r, " issue"}, act == e, act, e);
      else     check({r, " bubble"}, x_valid == 1'b0, x_valid, 1'b0);
    end
  end

  task automatic clear();
    id_valid = 1; id_hit = 1; id_pc = 32'h0000_1000;
    rf_data_a = 32'h0000_00A1; rf_data_b = 32'h0000_00B2;
    ex_wr_en = 0; ex_load = 0; ex_rd = 0; ex_result = 32'hE0E0_0001;
    mem_wr_en = 0; mem_rd = 0; mem_result = 32'h3E3E_0002;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", x_valid == 0, x_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", x_valid == 0, x_valid, 0);

    clear(); id_instr = rtype(1, 2, 3, 0); go("R2 add plain");
    clear(); id_instr = rtype(4, 5, 6, 1); ex_wr_en = 1; ex_rd = 4;
    mem_wr_en = 1; mem_rd = 5; go("R4 ex->a mem->b");
    clear(); id_instr = rtype(7, 7, 9, 3); ex_wr_en = 1; ex_rd = 7;
    mem_wr_en = 1; mem_rd = 7; go("R4 ex over mem");
    clear(); id_instr = rtype(0, 0, 2, 2); ex_wr_en = 1; ex_rd = 0;
    mem_wr_en = 1; mem_rd = 0; go("R4 reg0 no forward");
    clear(); id_instr = itype(1, 3, 8, 16'hFFF0); go("R2 addi negative");
    clear(); id_instr = rtype(3, 4, 0, 0); go("R2 dest zero");
    clear(); id_instr = itype(3, 2, 9, 16'h0010); mem_wr_en = 1; mem_rd = 9; go("R2 store data");
    clear(); id_instr = rtype(5, 2, 6, 0); ex_wr_en = 1; ex_load = 1; ex_rd = 5; go("R5 load-use a");
    clear(); id_instr = rtype(5, 2, 6, 0); mem_wr_en = 1; mem_rd = 5;
    mem_result = 32'h0000_ABCD; go("R5 after stall");
    clear(); id_instr = rtype(1, 12, 6, 1); ex_wr_en = 1; ex_load = 1; ex_rd = 12; go("R5 load-use b");
    clear(); id_instr = itype(2, 1, 12, 16'h0004); ex_wr_en = 1; ex_load = 1; ex_rd = 12; go("R6 load rt not source");
    clear(); id_instr = itype(1, 1, 12, 16'h0004); ex_wr_en = 1; ex_load = 1; ex_rd = 12; go("R6 addi rt not source");
    clear(); id_instr = itype(4, 1, 2, 16'hFFFC); rf_data_b = 32'h0000_00A1; go("R7 R8 beq taken");
    clear(); id_instr = itype(4, 1, 2, 16'h0020); go("R8 beq not taken");
    clear(); id_instr = itype(5, 1, 2, 16'h0020); go("R7 R8 bne taken");
    clear(); id_instr = itype(5, 1, 2, 16'h0020); mem_wr_en = 1; mem_rd = 2;
    mem_result = 32'h0000_00A1; go("R8 bne not taken fwd");
    clear(); id_pc = 32'h100; id_instr = itype(4, 7, 8, 16'hFFFC); ex_wr_en = 1; ex_rd = 7;
    ex_result = 32'h55; rf_data_b = 32'h55; go("R9 branch ex dep");
    clear(); id_pc = 32'h100; id_instr = itype(4, 7, 8, 16'hFFFC); rf_data_b = 32'h55;
    mem_wr_en = 1; mem_rd = 7; mem_result = 32'h55; go("R9 R7 branch resolved");
    clear(); id_hit = 0; id_instr = rtype(5, 2, 6, 0); ex_wr_en = 1; ex_load = 1; ex_rd = 5; go("R10 miss hazard");
    clear(); id_hit = 0; id_instr = itype(4, 1, 1, 16'h0008); go("R10 miss branch");
    clear(); id_instr = itype(63, 1, 1, 16'h0008); go("R11 bad opcode");
    clear(); id_instr = rtype(5, 2, 6, 0) | 32'h0000_0040; ex_wr_en = 1; ex_load = 1; ex_rd = 5;
    go("R11 bad reg op");
    clear(); id_valid = 0; id_instr = rtype(1, 2, 3, 0); go("R2 no fetch");
    clear(); id_valid = 0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule